// File: doc/BRIEF.md
# Open-Row DRAM Bank Reader

This block models a single small DRAM bank of sixteen 32-bit rows and the row buffer in front of it. A requester presents a row number together with a request strobe. The block compares that row with the row currently held open and answers with a latency that depends on the result of that comparison:

- **Hit:** the requested row is already open, and the answer appears in the same cycle.
- **Cold miss:** no row is open, and the answer appears one cycle later.
- **Conflict:** a different row is open, and the answer appears two cycles later.

Each answer carries the data, the row it came from and a response strobe. Every row holds its own index as contents. There is no write path.

A small state machine sequences the delayed answers. It has three states:

- `ST_IDLE`: nothing is pending.
- `ST_WAIT`: a conflict is waiting one more cycle.
- `ST_SHOW`: a delayed answer is on the outputs for one cycle.

Its transitions are:

- `IDLE_TO_SHOW`: a cold miss is accepted.
- `ANY_TO_WAIT`: a conflict is accepted from any state.
- `WAIT_TO_SHOW`: the wait ends with no new request.
- `SHOW_TO_IDLE`: the display cycle ends with no new request.
- `ANY_TO_IDLE`: a hit is accepted. The answer is produced combinationally, so nothing stays pending.
- `IDLE_HOLD`: the machine stays in `ST_IDLE` with no request.

A request accepted in `ST_WAIT` replaces the pending read.

Top module: `dram_row_reader`

## Requirements
- R1: After reset `rsp_valid` is 0 and no row is open, so the first request after reset takes the one-cycle cold-miss latency.
- R2: The data returned for row i is i, zero-extended to 32 bits, for every i from 0 to 15.
- R3: A request (`req_valid`=1) whose row equals the open row drives `rsp_valid`=1, `rsp_row`=`req_row` and that row's data in the same cycle.
- R4: A request made while no row is open gives `rsp_valid`=0 in its own cycle. It gives `rsp_valid`=1 with that row and data in the next cycle, and `rsp_valid`=0 in the cycle after that if no new request is made.
- R5: A request to a row other than the open row gives `rsp_valid`=0 in its own cycle and in the next cycle. It gives `rsp_valid`=1 with that row and data in the second cycle after the request, for exactly one cycle.
- R6: While `req_valid` is 0, `req_row` is ignored: it neither produces a response nor changes the open row.
- R7: Every accepted request makes its row the open row, so a later request to it is a hit. This holds even while its own delayed answer is still pending.
- R8: A request accepted while a conflict read is pending cancels that read: its answer never appears, and only the new request is answered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| req_row | input | 4 | Requested row number |
| rsp_valid | output | 1 | A new answer is on `rsp_row`/`rsp_data` this cycle |
| rsp_row | output | 4 | Row number of the answer |
| rsp_data | output | 32 | Contents of the answered row |

## Verification
The bench counts cycles from the cycle in which a request is driven, which is cycle 0:

- a hit is checked in cycle 0;
- a cold miss is checked in cycle 1;
- a conflict is checked in cycle 2.

In every cycle where no answer is due, including cycle 0 of a miss and cycle 1 of a conflict, the bench checks that `rsp_valid` is 0. Inputs change on the falling edge, and outputs are sampled a quarter period later, before the next rising edge. The combinational hit answer is therefore seen in its own cycle, and each registered answer is seen in the cycle after the edge that produced it.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SHOW = 2'd2
    } rd_state_e;

endpackage

// File: rtl/dram_bank_store.sv
module dram_bank_store #(
    parameter int ROWS  = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_row,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] cells [ROWS];

    // Each row is loaded with its own index at reset; there is no write port.
    for (genvar g = 0; g < ROWS; g++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= WIDTH'(g);
            end else begin
                cells[g] <= cells[g];
            end
        end
    end

    assign rd_data = cells[rd_row];

endmodule

// File: rtl/dram_open_tracker.sv
module dram_open_tracker #(
    parameter int ROWS = 16,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_row,
    output logic          open_valid,
    output logic [AW-1:0] open_row,
    output logic          hit,
    output logic          cold,
    output logic          conflict
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_valid <= 1'b0;
            open_row   <= '0;
        end else if (req_valid) begin
            open_valid <= 1'b1;
            open_row   <= req_row;
        end
    end

    always_comb begin
        hit      = req_valid && open_valid && (req_row == open_row);
        cold     = req_valid && !open_valid;
        conflict = req_valid && open_valid && (req_row != open_row);
    end

    AST_OPEN_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (open_valid && open_row == $past(req_row))); // R7

    AST_OPEN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(open_valid) && $stable(open_row))); // R6

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, cold, conflict})); // R3

endmodule

// File: rtl/dram_rd_fsm.sv
module dram_rd_fsm
    import dram_rd_pkg::*;
#(
    parameter int ROWS = 16,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          cold,
    input  logic          conflict,
    input  logic [AW-1:0] req_row,
    output logic          show,
    output logic [AW-1:0] held_row
);

    rd_state_e state_q, state_d;
    logic [AW-1:0] held_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            held_row <= '0;
        end else begin
            state_q  <= state_d;
            held_row <= held_d;
        end
    end

    // Next-state logic. New requests take priority in every state.
    always_comb begin
        state_d = state_q;
        held_d  = held_row;
        if (hit) begin
            state_d = ST_IDLE;                     // ANY_TO_IDLE
        end else if (cold) begin
            state_d = ST_SHOW;                     // IDLE_TO_SHOW
            held_d  = req_row;
        end else if (conflict) begin
            state_d = ST_WAIT;                     // ANY_TO_WAIT, cancels a pending read
            held_d  = req_row;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;        // IDLE_HOLD
                ST_WAIT: state_d = ST_SHOW;        // WAIT_TO_SHOW
                ST_SHOW: state_d = ST_IDLE;        // SHOW_TO_IDLE
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Output logic.
    always_comb begin
        show = (state_q == ST_SHOW);
    end

    AST_SHOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHOW && !cold && !conflict) |=> (state_q != ST_SHOW)); // R4

    AST_WAIT_THEN_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !hit && !cold && !conflict) |=> (state_q == ST_SHOW && $stable(held_row))); // R5

    AST_CONFLICT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> (state_q == ST_WAIT && held_row == $past(req_row))); // R8

    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3); // R1

endmodule

// File: rtl/dram_row_reader.sv
module dram_row_reader #(
    parameter int ROWS  = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_row,
    output logic             rsp_valid,
    output logic [AW-1:0]    rsp_row,
    output logic [WIDTH-1:0] rsp_data
);

    logic          open_valid;
    logic [AW-1:0] open_row;
    logic          hit, cold, conflict;
    logic          show;
    logic [AW-1:0] held_row;

    dram_open_tracker #(.ROWS(ROWS)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_row    (req_row),
        .open_valid (open_valid),
        .open_row   (open_row),
        .hit        (hit),
        .cold       (cold),
        .conflict   (conflict)
    );

    dram_rd_fsm #(.ROWS(ROWS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .cold     (cold),
        .conflict (conflict),
        .req_row  (req_row),
        .show     (show),
        .held_row (held_row)
    );

    // A hit in a display cycle can only name the displayed row, so it overrides safely.
    always_comb begin
        rsp_valid = hit || show;
        rsp_row   = hit ? req_row : held_row;
    end

    dram_bank_store #(.ROWS(ROWS), .WIDTH(WIDTH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (rsp_row),
        .rd_data (rsp_data)
    );

    AST_HIT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && open_valid && req_row == open_row) |-> (rsp_valid && rsp_row == req_row)); // R3

    AST_DATA_IS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data == WIDTH'(rsp_row))); // R2

    AST_COLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !open_valid) |=> (rsp_valid && rsp_row == $past(req_row))); // R4

    AST_CONFLICT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && open_valid && req_row != open_row) |=> (!rsp_valid || req_valid)); // R5

    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !show) |-> !rsp_valid); // R6

endmodule

// File: tb/test_dram_row_reader.sv
module test_dram_row_reader;

    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_row = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_row;
    logic [31:0] rsp_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #HALF clk = ~clk;

    dram_row_reader i_dram_row_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_row   (req_row),
        .rsp_valid (rsp_valid),
        .rsp_row   (rsp_row),
        .rsp_data  (rsp_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive on the falling edge, then sample a quarter period later.
    task automatic cyc(input logic v, input logic [3:0] r);
        @(negedge clk);
        req_valid = v;
        req_row   = r;
        #(HALF/2);
    endtask

    task automatic expect_rsp(input string tag, input logic [3:0] r);
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " row"},   32'(rsp_row),   32'(r));
        chk({tag, " data"},  rsp_data,       32'(r));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        cyc(1'b0, 4'd0);
        chk("R1 idle after reset", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_cold_miss();
        cyc(1'b1, 4'd5);
        chk("R4 cold cycle0", 32'(rsp_valid), 32'd0);
        cyc(1'b0, 4'd0);
        expect_rsp("R4 cold cycle1", 4'd5);
        cyc(1'b0, 4'd0);
        chk("R4 cold one cycle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_hit();
        cyc(1'b1, 4'd5);
        expect_rsp("R3 hit same cycle", 4'd5);
        cyc(1'b0, 4'd0);
        chk("R3 hit no echo", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_conflict();
        cyc(1'b1, 4'd9);
        chk("R5 conflict cycle0", 32'(rsp_valid), 32'd0);
        cyc(1'b0, 4'd0);
        chk("R5 conflict cycle1", 32'(rsp_valid), 32'd0);
        cyc(1'b0, 4'd0);
        expect_rsp("R5 conflict cycle2", 4'd9);
        cyc(1'b0, 4'd0);
        chk("R5 conflict one cycle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_ignored();
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 4'(k + 3));
            chk("R6 strobe low ignored", 32'(rsp_valid), 32'd0);
        end
        cyc(1'b1, 4'd9);
        expect_rsp("R6 open row unchanged", 4'd9);
    endtask

    task automatic t_cancel();
        cyc(1'b1, 4'd2);
        chk("R8 first conflict c0", 32'(rsp_valid), 32'd0);
        cyc(1'b1, 4'd7);
        chk("R8 second conflict c0", 32'(rsp_valid), 32'd0);
        cyc(1'b0, 4'd0);
        chk("R8 cancelled read absent", 32'(rsp_valid), 32'd0);
        cyc(1'b0, 4'd0);
        expect_rsp("R8 new read answered", 4'd7);
        cyc(1'b0, 4'd0);
        chk("R8 single answer", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_hit_while_pending();
        cyc(1'b1, 4'd4);
        chk("R7 conflict c0", 32'(rsp_valid), 32'd0);
        cyc(1'b1, 4'd4);
        expect_rsp("R7 pending row is open", 4'd4);
        cyc(1'b0, 4'd0);
        chk("R7 pending replaced by hit", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_all_rows();
        for (int r = 0; r < 16; r++) begin
            cyc(1'b1, 4'(r));
            cyc(1'b0, 4'd0);
            cyc(1'b0, 4'd0);
            expect_rsp("R2 row contents", 4'(r));
        end
    endtask

    task automatic t_reset_closes_row();
        do_reset();
        cyc(1'b1, 4'd15);
        chk("R1 no open row after reset", 32'(rsp_valid), 32'd0);
        cyc(1'b0, 4'd0);
        expect_rsp("R1 cold latency after reset", 4'd15);
    endtask

    initial begin
        t_reset_state();
        t_cold_miss();
        t_hit();
        t_conflict();
        t_ignored();
        t_cancel();
        t_hit_while_pending();
        t_all_rows();
        t_reset_closes_row();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule